// File: doc/BRIEF.md
# Multifunction Pin Routing Controller

This block sits between four general-purpose bidirectional pads and the core of a chip. Each pad can serve in one of two roles. As a control input it carries a level from the board into the core and drives one internal control signal. As a status output it shows one internal status signal on the pad. A one-byte configuration register per pad holds the role and a function code. The function code picks which control signal the pad drives, or which status signal it shows.

A global enable register gates the whole feature. Until software writes exactly 0x01 to it, every pad stays an input with its output driver off, and every control signal sits at its inactive level. Pad inputs cross into the core clock domain through two flops before they are decoded.

Two or more pads may be set to drive the same control signal. In that case a fixed priority gives the signal to the pad with the lowest index, and the other pads are ignored for that signal. Power-up strapping is out of scope. After reset the pads follow only the programmed registers.

Top module: `mfp_router`

## Requirements
- R1: After reset the enable register and all four configuration registers hold 0x00. Every pad output enable, pad output and control output is then 0.
- R2: The feature is active only while the enable register holds exactly 0x01. For any other value (for example 0x00 or 0x03), all pad output enables, pad outputs and control outputs are 0.
- R3: A write with reg_we high at a rising edge updates the register at reg_addr, and the new value takes effect right after that edge. Address 0 is the enable register and addresses 1 to 4 are the configuration registers of pads 0 to 3. A write to addresses 5 to 7 changes nothing seen at the ports.
- R4: A configuration byte with bit 7 set puts its pad in status mode. pad_oe is 1, and pad_out equals status_in[code], where code is bits 6:0, in the same cycle that status_in changes.
- R5: A configuration byte with bit 7 clear puts its pad in control mode with pad_oe 0. ctrl_out[code] then follows pad_in of that pad. A change at pad_in first shows on ctrl_out after the second rising edge that samples it.
- R6: When several enabled control-mode pads carry the same code, ctrl_out[code] follows only the pad with the smallest index. Changes on the other pads have no effect on it.
- R7: A control output that no enabled control-mode pad selects is held at 0. Status-mode pads never drive control outputs.
- R8: A control code of NUM_CTRL or more selects nothing. A status-mode pad whose code is NUM_STAT or more drives pad_out to 0 while keeping pad_oe at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 enable, 1..4 pad configuration) |
| reg_wdata | input | 8 | Register write data |
| pad_in | input | NUM_PINS | Levels received from the pads |
| status_in | input | NUM_STAT | Internal status signals available for display |
| pad_out | output | NUM_PINS | Levels driven onto the pads |
| pad_oe | output | NUM_PINS | Pad output driver enables |
| ctrl_out | output | NUM_CTRL | Internal control signals driven from the pads |

## Verification
The assertions assume that reg_addr and reg_wdata hold a defined value whenever reg_we is high. They also assume that status_in is known and stable around the rising clock edge. The bench meets both assumptions by driving every input on the falling edge and holding the write fields steady for a whole cycle. The pad inputs may change at any time, so they carry no assumption. The bench still changes them only on falling edges, so that the two-flop delay can be counted exactly.

// File: rtl/mfp_pkg.sv
package mfp_pkg;
    localparam int NUM_PINS = 4;
    localparam int CFG_W    = 8;
    localparam int CODE_W   = CFG_W - 1;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CFG0   = 3'd1;
    localparam logic [CFG_W-1:0]  ENABLE_KEY  = 8'h01;

    typedef struct packed {
        logic              monitor;
        logic [CODE_W-1:0] code;
    } pin_cfg_t;
endpackage

// File: rtl/mfp_regs.sv
module mfp_regs
    import mfp_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic [CFG_W-1:0]              reg_wdata,
    output logic                          active_o,
    output pin_cfg_t [NUM_PINS-1:0]       cfg_o
);
    typedef struct packed {
        logic [CFG_W-1:0]        enable;
        pin_cfg_t [NUM_PINS-1:0] cfg;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (reg_we) begin
            if (reg_addr == ADDR_ENABLE) begin
                st_d.enable = reg_wdata;
            end
            for (int i = 0; i < NUM_PINS; i++) begin
                if (reg_addr == ADDR_CFG0 + ADDR_W'(i)) begin
                    st_d.cfg[i] = pin_cfg_t'(reg_wdata);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = (st_q.enable == ENABLE_KEY);
    assign cfg_o    = st_q.cfg;

    assert_enable_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_ENABLE) |=> (st_q.enable == $past(reg_wdata)));

    assert_unmapped_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && int'(reg_addr) > NUM_PINS) |=> $stable(st_q));

    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(st_q));
endmodule

// File: rtl/mfp_sync.sv
module mfp_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] stage1;
        logic [WIDTH-1:0] stage2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.stage1 = async_i;
        st_d.stage2 = st_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.stage2;

    assert_two_stage_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sync_o == $past(st_q.stage1)));
endmodule

// File: rtl/mfp_ctrl_arb.sv
module mfp_ctrl_arb
    import mfp_pkg::*;
#(
    parameter int NUM_CTRL = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    active_i,
    input  pin_cfg_t [NUM_PINS-1:0] cfg_i,
    input  logic [NUM_PINS-1:0]     pad_sync_i,
    output logic [NUM_CTRL-1:0]     ctrl_o
);
    logic [NUM_CTRL-1:0][NUM_PINS-1:0] want;
    logic [NUM_CTRL-1:0][NUM_PINS-1:0] grant;

    for (genvar k = 0; k < NUM_CTRL; k++) begin : g_func
        always_comb begin
            for (int i = 0; i < NUM_PINS; i++) begin
                want[k][i] = active_i && !cfg_i[i].monitor
                             && (int'(cfg_i[i].code) == k);
            end
        end

        always_comb begin
            logic taken;
            taken    = 1'b0;
            grant[k] = '0;
            for (int i = 0; i < NUM_PINS; i++) begin
                if (want[k][i] && !taken) begin
                    grant[k][i] = 1'b1;
                    taken       = 1'b1;
                end
            end
        end

        assign ctrl_o[k] = |(grant[k] & pad_sync_i);

        assert_single_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[k]));

        assert_pin0_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
            want[k][0] |-> grant[k][0]);

        assert_unselected_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (want[k] == '0) |-> !ctrl_o[k]);
    end
endmodule

// File: rtl/mfp_mon_mux.sv
module mfp_mon_mux
    import mfp_pkg::*;
#(
    parameter int NUM_STAT = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    active_i,
    input  pin_cfg_t [NUM_PINS-1:0] cfg_i,
    input  logic [NUM_STAT-1:0]     status_i,
    output logic [NUM_PINS-1:0]     pad_out_o,
    output logic [NUM_PINS-1:0]     pad_oe_o
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic picked;

        always_comb begin
            picked = 1'b0;
            for (int s = 0; s < NUM_STAT; s++) begin
                if (int'(cfg_i[p].code) == s) begin
                    picked = status_i[s];
                end
            end
        end

        assign pad_oe_o[p]  = active_i && cfg_i[p].monitor;
        assign pad_out_o[p] = pad_oe_o[p] && picked;

        assert_bad_code_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(cfg_i[p].code) >= NUM_STAT) |-> !pad_out_o[p]);

        assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !active_i |-> (!pad_oe_o[p] && !pad_out_o[p]));
    end
endmodule

// File: rtl/mfp_router.sv
module mfp_router
    import mfp_pkg::*;
#(
    parameter int NUM_CTRL = 6,
    parameter int NUM_STAT = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    input  logic [3:0]          pad_in,
    input  logic [NUM_STAT-1:0] status_in,
    output logic [3:0]          pad_out,
    output logic [3:0]          pad_oe,
    output logic [NUM_CTRL-1:0] ctrl_out
);
    logic                    active;
    pin_cfg_t [NUM_PINS-1:0] cfg;
    logic [NUM_PINS-1:0]     pad_sync;

    mfp_regs i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .active_o  (active),
        .cfg_o     (cfg)
    );

    mfp_sync #(.WIDTH(NUM_PINS)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pad_in),
        .sync_o  (pad_sync)
    );

    mfp_ctrl_arb #(.NUM_CTRL(NUM_CTRL)) i_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .cfg_i      (cfg),
        .pad_sync_i (pad_sync),
        .ctrl_o     (ctrl_out)
    );

    mfp_mon_mux #(.NUM_STAT(NUM_STAT)) i_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active),
        .cfg_i     (cfg),
        .status_i  (status_in),
        .pad_out_o (pad_out),
        .pad_oe_o  (pad_oe)
    );

    assert_ctrl_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (ctrl_out == '0));

    assert_out_needs_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out & ~pad_oe) == '0));

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && ctrl_out == '0));
endmodule

// File: tb/test_mfp_router.sv
module test_mfp_router;
    localparam int CLK_PERIOD = 10;
    localparam int NCTRL = 6;
    localparam int NSTAT = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_we = 1'b0;
    logic [2:0]       reg_addr = '0;
    logic [7:0]       reg_wdata = '0;
    logic [3:0]       pad_in = '0;
    logic [NSTAT-1:0] status_in = '0;
    logic [3:0]       pad_out, pad_oe;
    logic [NCTRL-1:0] ctrl_out;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string cur_req = "R1 reset state";

    // reference model state
    logic [7:0] m_en;
    logic [7:0] m_cfg [4];
    logic [3:0] m_s1, m_s2;

    always #(CLK_PERIOD/2) clk = ~clk;

    mfp_router #(.NUM_CTRL(NCTRL), .NUM_STAT(NSTAT)) i_mfp_router (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pad_in(pad_in), .status_in(status_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .ctrl_out(ctrl_out)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_en <= 8'h00;
            for (int i = 0; i < 4; i++) m_cfg[i] <= 8'h00;
            m_s1 <= '0;
            m_s2 <= '0;
        end else begin
            if (reg_we) begin
                if (reg_addr == 3'd0) m_en <= reg_wdata;
                else if (reg_addr >= 3'd1 && reg_addr <= 3'd4) m_cfg[reg_addr - 3'd1] <= reg_wdata;
            end
            m_s1 <= pad_in;
            m_s2 <= m_s1;
        end
    end

    task automatic compare_now();
        logic [3:0]       e_oe, e_out;
        logic [NCTRL-1:0] e_ctrl;
        bit               on;
        on = (m_en == 8'h01);
        e_oe = '0; e_out = '0; e_ctrl = '0;
        for (int i = 0; i < 4; i++) begin
            if (on && m_cfg[i][7]) begin
                e_oe[i] = 1'b1;
                if (m_cfg[i][6:0] < NSTAT) e_out[i] = status_in[m_cfg[i][6:0]];
            end
        end
        // scan from highest pin down so the lowest pin is applied last
        for (int i = 3; i >= 0; i--) begin
            if (on && !m_cfg[i][7] && m_cfg[i][6:0] < NCTRL)
                e_ctrl[m_cfg[i][6:0]] = m_s2[i];
        end
        checks++;
        if (pad_oe !== e_oe || pad_out !== e_out || ctrl_out !== e_ctrl) begin
            errors++;
            $display("FAIL %s: oe=%b out=%b ctrl=%b expected oe=%b out=%b ctrl=%b",
                     cur_req, pad_oe, pad_out, ctrl_out, e_oe, e_out, e_ctrl);
        end
    endtask

    always @(negedge clk) if (!done) compare_now();

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wiggle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pad_in    = 4'($urandom);
            status_in = NSTAT'($urandom);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        @(negedge clk) rst_n = 1'b1;
        cur_req = "R1 reset state";
        wiggle(6);

        cur_req = "R2 wrong enable key";
        wr(3'd1, 8'h82);
        wr(3'd2, 8'h03);
        wr(3'd0, 8'h03);
        wiggle(8);

        cur_req = "R3 unmapped address write";
        wr(3'd5, 8'hFF);
        wr(3'd7, 8'h01);
        wiggle(4);

        cur_req = "R4 status display";
        wr(3'd0, 8'h01);
        wr(3'd4, 8'h89);
        wiggle(12);

        cur_req = "R5 control latency";
        wr(3'd1, 8'h00);
        pad_in = 4'b0000; tick(3);
        pad_in = 4'b0001; tick(1);
        pad_in = 4'b0000; tick(3);
        wiggle(10);

        cur_req = "R6 lowest pin wins";
        wr(3'd1, 8'h02);
        wr(3'd2, 8'h02);
        wr(3'd3, 8'h02);
        wiggle(12);
        pad_in = 4'b1110; tick(3);
        pad_in = 4'b0001; tick(3);
        wr(3'd1, 8'h80);
        wiggle(10);

        cur_req = "R7 unselected controls idle";
        wr(3'd1, 8'h05);
        wr(3'd2, 8'h81);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h00);
        pad_in = 4'b1111; tick(4);
        wiggle(10);

        cur_req = "R8 out of range codes";
        wr(3'd1, 8'h7F);
        wr(3'd2, 8'hFF);
        wr(3'd3, 8'h0A);
        wr(3'd4, 8'h8A);
        status_in = '1; pad_in = 4'b1111; tick(4);
        wiggle(8);

        cur_req = "R2 disable while configured";
        wr(3'd1, 8'h01);
        wr(3'd0, 8'h00);
        wiggle(8);
        wr(3'd0, 8'h01);
        wiggle(6);

        cur_req = "R1 reset state after rerun";
        @(negedge clk) rst_n = 1'b0;
        tick(2);
        @(negedge clk) rst_n = 1'b1;
        wiggle(6);

        finish_run();
    end
endmodule